// File: doc/BRIEF.md
# Serial Byte-Addressed Memory Slave with Write Protection

This block is a serial slave that puts a byte array behind a four-wire synchronous serial port. It behaves as a RAM with no write delay. Every input pin (select, serial clock, data in, write-protect, hold) is brought into the system clock domain and edge-detected. A command decoder then runs the transfer in serial mode 0: input bits are sampled on the rising serial-clock edge and output bits change on the falling edge. Data out comes with an output-enable that stands for the tri-state control of the pin.

Writes land in the array one byte at a time, as soon as each byte is complete. No staging buffer is used and a burst has no length limit. Writes are gated by an enable latch that a separate command must set first. A small status register holds a write-protect-enable bit and a two-bit range selector that fences off the upper part of the array. A hold pin can freeze a transfer part-way through and resume it later without losing its place. The array depth is 2^ADDR_W bytes. Addresses arrive as three bytes, and only the low ADDR_W bits are kept.

Top module: `spimem_top`

## Requirements
- R1: Command 06h sets the write-enable latch (WEL). Command 02h (array write) and command 01h (status write) are accepted only while WEL is set. Otherwise the rest of the transfer is ignored.
- R2: Commands 02h, 03h and 0Bh are followed by three address bytes, sent most significant byte first. Only the low ADDR_W bits select the first byte.
- R3: The address moves up by one after each data byte for as long as clocks continue. After address 2^ADDR_W-1 it continues at 0.
- R4: Serial mode 0 is used. Bits enter on the rising serial-clock edge and leave on the falling edge, most significant bit first in both directions.
- R5: In a write, each byte is committed when its 8th bit arrives, and any number of bytes may follow. The select rising edge that ends an array write or a status write clears WEL.
- R6: Command 03h streams bytes from the address onward. Data in is ignored during the data bytes. miso_oe is 1 while data is being driven and 0 once select is high.
- R7: Command 0Bh takes one dummy byte after the address. Its output then matches a 03h read of the same address.
- R8: Command 05h returns the status byte: bit 7 = WPEN, bits 3:2 = BP, bit 1 = WEL, all other bits 0. The byte reads 00h after reset.
- R9: Command 01h loads WPEN from bit 7 and BP from bits 3:2 of the next byte. The load is refused when WPEN is 1 and wp_n was low at the select falling edge. A change of wp_n inside the transfer has no effect on that transfer.
- R10: BP = 01 protects the top quarter of the array, 10 the top half and 11 the whole array. Writes to protected bytes are dropped, while the address still advances.
- R11: When hold_n goes low while the serial clock is low, the transfer freezes and miso_oe is 0. Clock edges are ignored while frozen. Raising hold_n while the clock is low resumes the transfer exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| hold_n | input | 1 | Transfer pause pin, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Drive enable for miso (0 = high impedance) |

## Verification
Two functions fall on the same rising serial-clock edge:
- the commit of the final byte of the array, together with the address counter wrapping to zero;
- the range-protection decision, which must use the address from before the increment.

The bench provokes this with a two-byte burst starting at the top address while the top quarter is protected. It then reads both locations back and expects the top byte unchanged and byte 0 updated. A second collision puts a hold in the middle of a byte during both a read and a write. The bench judges that case by whether the reassembled byte matches the undisturbed one.

// File: rtl/spimem_pkg.sv
`timescale 1ns/1ps
package spimem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_SRRD  = 8'h05;
  localparam logic [7:0] OP_SRWR  = 8'h01;

  typedef enum logic [2:0] {
    PH_SKIP, PH_CMD, PH_ADDR, PH_DUMMY, PH_WDATA, PH_RDATA, PH_SRW, PH_SRR
  } phase_t;

  typedef enum logic [1:0] {ACC_WR, ACC_RD, ACC_FAST} access_t;
endpackage

// File: rtl/spimem_sync.sv
`timescale 1ns/1ps
module spimem_sync #(
  parameter int          W       = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[i]    = s2;
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/spimem_array.sv
`timescale 1ns/1ps
module spimem_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
  assign rdata = mem[addr];
endmodule

// File: rtl/spimem_ctrl.sv
`timescale 1ns/1ps
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi,
  input  logic          wp_n,
  input  logic          hold_n,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          miso,
  output logic          miso_oe,
  output logic          wel_o,
  output logic          held_o,
  output logic [1:0]    bp_o
);
  phase_t        phase_q, phase_d;
  access_t       acc_q, acc_d;
  logic [2:0]    bcnt_q, bcnt_d;
  logic [1:0]    acnt_q, acnt_d;
  logic [6:0]    shin_q, shin_d;
  logic [7:0]    shout_q, shout_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          oe_q, oe_d, wel_q, wel_d, wpen_q, wpen_d;
  logic [1:0]    bp_q, bp_d;
  logic          wplat_q, wplat_d, held_q, held_d, wend_q, wend_d;

  logic [7:0]    byte_in, status;
  logic [AW+7:0] addr_cat;
  logic          byte_done, shifting;

  function automatic logic in_fence(input logic [1:0] b, input logic [AW-1:0] a);
    case (b)
      2'b01:   return a[AW-1:AW-2] == 2'b11;
      2'b10:   return a[AW-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign byte_in   = {shin_q, mosi};
  assign status    = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  assign addr_cat  = {addr_q, byte_in};
  assign byte_done = sck_rise && (bcnt_q == 3'd7);
  assign shifting  = (phase_q == PH_RDATA) || (phase_q == PH_SRR);

  always_comb begin
    phase_d = phase_q;  acc_d  = acc_q;   bcnt_d  = bcnt_q;  acnt_d = acnt_q;
    shin_d  = shin_q;   shout_d = shout_q; addr_d = addr_q;  oe_d   = oe_q;
    wel_d   = wel_q;    wpen_d = wpen_q;  bp_d    = bp_q;    wplat_d = wplat_q;
    wend_d  = wend_q;   held_d = held_q;
    mem_we  = 1'b0;
    if (!sck) held_d = !hold_n;
    if (cs_fall) begin
      phase_d = PH_CMD; bcnt_d = '0; acnt_d = '0; oe_d = 1'b0;
      wplat_d = wp_n;   wend_d = 1'b0;
    end else if (cs_rise) begin
      phase_d = PH_SKIP; oe_d = 1'b0;
      if (wend_q) wel_d = 1'b0;
    end else if (!cs_n && !held_q) begin
      if (sck_rise) begin
        shin_d = byte_in[6:0];
        bcnt_d = bcnt_q + 3'd1;
      end
      if (byte_done) begin
        case (phase_q)
          PH_CMD: begin
            phase_d = PH_SKIP;
            case (byte_in)
              OP_WREN:  wel_d = 1'b1;
              OP_WRITE: if (wel_q) begin
                phase_d = PH_ADDR; acc_d = ACC_WR; wend_d = 1'b1;
              end
              OP_READ:  begin phase_d = PH_ADDR; acc_d = ACC_RD;   end
              OP_FAST:  begin phase_d = PH_ADDR; acc_d = ACC_FAST; end
              OP_SRRD:  phase_d = PH_SRR;
              OP_SRWR:  if (wel_q) begin phase_d = PH_SRW; wend_d = 1'b1; end
              default:  phase_d = PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            addr_d = addr_cat[AW-1:0];
            acnt_d = acnt_q + 2'd1;
            if (acnt_q == 2'd2) begin
              case (acc_q)
                ACC_WR:  phase_d = PH_WDATA;
                ACC_RD:  phase_d = PH_RDATA;
                default: phase_d = PH_DUMMY;
              endcase
            end
          end
          PH_DUMMY: phase_d = PH_RDATA;
          PH_WDATA: begin
            mem_we = !in_fence(bp_q, addr_q);
            addr_d = addr_q + AW'(1);
          end
          PH_SRW: begin
            if (!(wpen_q && !wplat_q)) begin
              wpen_d = byte_in[7];
              bp_d   = byte_in[3:2];
            end
            phase_d = PH_SKIP;
          end
          default: ;
        endcase
      end else if (sck_fall && shifting) begin
        if (bcnt_q == 3'd0) begin
          oe_d = 1'b1;
          if (phase_q == PH_RDATA) begin
            shout_d = mem_rdata;
            addr_d  = addr_q + AW'(1);
          end else begin
            shout_d = status;
          end
        end else begin
          shout_d = {shout_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SKIP; acc_q <= ACC_RD; bcnt_q <= '0; acnt_q <= '0;
      shin_q <= '0; shout_q <= '0; addr_q <= '0; oe_q <= 1'b0;
      wel_q <= 1'b0; wpen_q <= 1'b0; bp_q <= 2'b00; wplat_q <= 1'b1;
      held_q <= 1'b0; wend_q <= 1'b0;
    end else begin
      phase_q <= phase_d; acc_q <= acc_d; bcnt_q <= bcnt_d; acnt_q <= acnt_d;
      shin_q <= shin_d; shout_q <= shout_d; addr_q <= addr_d; oe_q <= oe_d;
      wel_q <= wel_d; wpen_q <= wpen_d; bp_q <= bp_d; wplat_q <= wplat_d;
      held_q <= held_d; wend_q <= wend_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = byte_in;
  assign miso      = shout_q[7];
  assign miso_oe   = oe_q && !held_q && !cs_n;
  assign wel_o     = wel_q;
  assign held_o    = held_q;
  assign bp_o      = bp_q;
endmodule

// File: rtl/spimem_top.sv
`timescale 1ns/1ps
module spimem_top #(
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  input  logic hold_n,
  output logic miso,
  output logic miso_oe
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] PIN_RST = 5'b11001;

  logic rst_m, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  logic [NPIN-1:0] pin_q, pin_rise, pin_fall;
  spimem_sync #(.W(NPIN), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({hold_n, wp_n, mosi, sck, cs_n}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  logic              cs_s, mem_we, wel, held;
  logic [1:0]        bp;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic [2:0]        unused_edges;

  assign cs_s         = pin_q[0];
  assign unused_edges = {pin_rise[4] | pin_fall[4], pin_rise[3] | pin_fall[3],
                         pin_rise[2] | pin_fall[2]};

  spimem_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_n(cs_s), .cs_fall(pin_fall[0]), .cs_rise(pin_rise[0]),
    .sck(pin_q[1]), .sck_rise(pin_rise[1]), .sck_fall(pin_fall[1]),
    .mosi(pin_q[2]), .wp_n(pin_q[3]), .hold_n(pin_q[4]),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(cur_addr),
    .mem_wdata(mem_wdata), .miso(miso), .miso_oe(miso_oe),
    .wel_o(wel), .held_o(held), .bp_o(bp)
  );

  spimem_array #(.AW(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .addr(cur_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spimem_chk.sv
`timescale 1ns/1ps
module spimem_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          held,
  input logic          wel,
  input logic [1:0]    bp,
  input logic          mem_we,
  input logic [AW-1:0] addr,
  input logic          miso_oe
);
  // R1: no array write unless the enable latch is set
  a_r1_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  // R10: whole-array fence blocks every write
  a_r10_full_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == 2'b11) |-> !mem_we);

  // R6: output never driven while deselected
  a_r6_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !miso_oe);

  // R11: frozen transfer writes nothing and keeps its address
  a_r11_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!mem_we && !miso_oe));

  a_r11_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(addr));
endmodule

bind spimem_top spimem_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cs_s(cs_s), .held(held), .wel(wel),
  .bp(bp), .mem_we(mem_we), .addr(cur_addr), .miso_oe(miso_oe)
);

// File: tb/tb_spimem_top.sv
`timescale 1ns/1ps
module tb_spimem_top;
  localparam time HALF = 64ns;

  logic clk, rst_n, cs_n, sck, mosi, wp_n, hold_n;
  logic miso, miso_oe;
  int   checks = 0, errors = 0;
  bit   done = 0;

  spimem_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    #HALF;
    r = miso;
    sck = 1'b1;
    #HALF;
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic cs_begin;
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_end;
    #HALF;
    cs_n = 1'b1;
    #(3*HALF);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r;
    xbyte(a[23:16], r); xbyte(a[15:8], r); xbyte(a[7:0], r);
  endtask

  task automatic do_wren;
    logic [7:0] r;
    cs_begin; xbyte(8'h06, r); cs_end;
  endtask

  task automatic mem_write(input logic [23:0] a, input logic [31:0] d, input int n);
    logic [7:0] r;
    cs_begin; xbyte(8'h02, r); send_addr(a);
    for (int i = 0; i < n; i++) xbyte(d[8*(n-1-i) +: 8], r);
    cs_end;
  endtask

  task automatic mem_read(input logic [7:0] op, input logic [23:0] a, input int n,
                          input logic [7:0] fill, output logic [31:0] q,
                          output logic oe_in, output logic oe_after);
    logic [7:0] b;
    q = '0;
    cs_begin; xbyte(op, b); send_addr(a);
    if (op == 8'h0B) xbyte(fill, b);
    for (int i = 0; i < n; i++) begin
      xbyte(fill, b);
      q = {q[23:0], b};
    end
    oe_in = miso_oe;
    cs_end;
    oe_after = miso_oe;
  endtask

  task automatic sr_write(input logic [7:0] v);
    logic [7:0] r;
    cs_begin; xbyte(8'h01, r); xbyte(v, r); cs_end;
  endtask

  task automatic sr_read(output logic [7:0] v);
    logic [7:0] r;
    cs_begin; xbyte(8'h05, r); xbyte(8'h00, v); cs_end;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R6 oe after reset", miso_oe, 0);
    sr_read(s);
    chk("R8 status after reset", s, 8'h00);
  endtask

  task automatic t_enable_gate;
    logic [7:0] s; logic [31:0] q; logic a, b;
    do_wren; sr_read(s);
    chk("R1 WEL set by 06h", s, 8'h02);
    mem_write(24'h000005, 32'h11, 1);
    sr_read(s);
    chk("R5 WEL cleared at end of write", s, 8'h00);
    mem_write(24'h000005, 32'hAA, 1);
    mem_read(8'h03, 24'h000005, 1, 8'h00, q, a, b);
    chk("R1 write without WEL ignored", q, 32'h11);
  endtask

  task automatic t_burst;
    logic [31:0] q; logic a, b;
    do_wren;
    mem_write(24'hABCD10, 32'hC3A55A3C, 4);
    mem_read(8'h03, 24'h000010, 4, 8'h00, q, a, b);
    chk("R2 R3 R4 R5 burst readback", q, 32'hC3A55A3C);
    chk("R6 oe during read", a, 1);
    chk("R6 oe after select high", b, 0);
    mem_read(8'h03, 24'h000012, 2, 8'hFF, q, a, b);
    chk("R6 data-in ignored during read", q, 32'h5A3C);
  endtask

  task automatic t_fast;
    logic [31:0] q; logic a, b;
    mem_read(8'h0B, 24'h000011, 2, 8'h96, q, a, b);
    chk("R7 fast read with dummy byte", q, 32'hA55A);
  endtask

  task automatic t_wrap;
    logic [31:0] q; logic a, b;
    do_wren;
    mem_write(24'h0000FF, 32'h7E81, 2);
    mem_read(8'h03, 24'h0000FF, 2, 8'h00, q, a, b);
    chk("R3 wrap top to zero", q, 32'h7E81);
  endtask

  task automatic t_fence;
    logic [31:0] q; logic a, b; logic [7:0] s;
    do_wren; mem_write(24'h0000BF, 32'h1122, 2);
    do_wren; sr_write(8'h04);
    sr_read(s);
    chk("R9 BP load", s, 8'h04);
    do_wren; mem_write(24'h0000BF, 32'h3344, 2);
    mem_read(8'h03, 24'h0000BF, 2, 8'h00, q, a, b);
    chk("R10 top quarter fenced", q, 32'h3322);
    do_wren; mem_write(24'h0000FF, 32'h9966, 2);
    mem_read(8'h03, 24'h0000FF, 2, 8'h00, q, a, b);
    chk("R10 R3 fenced top, wrapped byte written", q, 32'h7E66);
    do_wren; sr_write(8'h0C);
    do_wren; mem_write(24'h000010, 32'hEE, 1);
    mem_read(8'h03, 24'h000010, 1, 8'h00, q, a, b);
    chk("R10 whole array fenced", q, 32'hC3);
    do_wren; sr_write(8'h00);
  endtask

  task automatic t_wp;
    logic [7:0] s, r;
    do_wren; sr_write(8'h84);
    sr_read(s);
    chk("R9 WPEN load with wp_n high", s, 8'h84);
    wp_n = 1'b0;
    do_wren; sr_write(8'h00);
    sr_read(s);
    chk("R9 status write refused", s, 8'h84);
    wp_n = 1'b1;
    do_wren;
    cs_begin; xbyte(8'h01, r);
    wp_n = 1'b0;
    xbyte(8'h00, r); cs_end;
    wp_n = 1'b1;
    sr_read(s);
    chk("R9 wp_n change mid-transfer ignored", s, 8'h00);
  endtask

  task automatic freeze(input logic m);
    hold_n = 1'b0;
    #HALF;
    chk("R11 oe low while held", miso_oe, 0);
    for (int i = 0; i < 3; i++) begin
      mosi = m;
      sck = 1'b1; #HALF;
      sck = 1'b0; #HALF;
    end
    hold_n = 1'b1;
    #HALF;
  endtask

  task automatic t_hold;
    logic [7:0] r, b1, b2; logic [31:0] q; logic a, b;
    cs_begin; xbyte(8'h03, r); send_addr(24'h000010);
    for (int i = 7; i >= 4; i--) xbit(1'b0, b1[i]);
    freeze(1'b1);
    for (int i = 3; i >= 0; i--) xbit(1'b0, b1[i]);
    xbyte(8'h00, b2);
    cs_end;
    chk("R11 read resumes after hold", {b1, b2}, 16'hC3A5);
    do_wren;
    cs_begin; xbyte(8'h02, r); send_addr(24'h000020);
    for (int i = 7; i >= 5; i--) xbit(r[0] ^ r[0] ^ (8'hB4 >> i), r[0]);
    freeze(1'b1);
    for (int i = 4; i >= 0; i--) xbit(8'hB4 >> i, r[0]);
    cs_end;
    mem_read(8'h03, 24'h000020, 1, 8'h00, q, a, b);
    chk("R11 write resumes after hold", q, 32'hB4);
  endtask

  initial begin
    #1_500_000ns;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1; hold_n = 1'b1;
    #101ns;
    rst_n = 1'b1;
    #(2*HALF);
    t_reset;
    t_enable_gate;
    t_burst;
    t_fast;
    t_wrap;
    t_fence;
    t_wp;
    t_hold;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule